// File: doc/BRIEF.md
# Selectable Serial Test Pattern Checker

This block sits behind a serial receiver's deserializer and checks each recovered parallel word against a reference pattern. A 3-bit mode input selects the pattern: off, a toggling bit stream, one of three PRBS lengths, or a repeating 20-bit pattern that software programs. The checker locks onto the incoming stream without help. It first fills its reference history from the received bits. After one clean word it switches to a free-running reference, so that a single bad bit shows up as a single mismatch.

Once the checker has locked, any mismatching bit sets a sticky fail flag. Writing a new mode or pulsing a clear input removes the flag. The flag can be routed to an alarm pin. This happens only when a 4-bit diagnostic select input holds the code 4'b0011. Within each word, bit 0 is the earliest serial bit.

Top module: `ptn_checker`

## Requirements
- R1: After reset, fail_o and alarm_o are 0, and the stored user pattern is 20'h66666.
- R2: Mode 3'b000 (off) and the reserved modes 3'b110 and 3'b111 never set fail_o, whatever data arrives.
- R3: Mode 3'b001 expects each serial bit to be the inverse of the bit before it. This is a toggle pattern with a period of two bits, in either phase.
- R4: Mode 3'b010 expects b[n] = b[n-7] ^ b[n-6]. Mode 3'b011 expects b[n] = b[n-23] ^ b[n-18]. Mode 3'b100 expects b[n] = b[n-31] ^ b[n-28]. Here b[n] is the serial stream, and data_i bit 0 is the earliest bit of a word.
- R5: Mode 3'b101 expects the stored 20-bit pattern repeated, with pattern bit 0 sent first, in any phase. Lock is allowed only when the last 20 received bits form a rotation of the stored pattern.
- R6: After a mode change, received bits fill the reference history. A word is judged only once the history holds enough bits: 1, 7, 23, 31 or 20 bits for modes 001 to 101. The first word judged clean locks the checker. Mismatches before lock never set fail_o.
- R7: In the PRBS modes, lock is refused while the seeded history for the selected length is all zeros.
- R8: After lock, a valid word with any mismatching bit sets fail_o from the next clock edge on.
- R9: fail_o is sticky. It is cleared by clear_i or by any change of mode_i. If a failing word and clear_i arrive in the same cycle, fail_o is set.
- R10: A word presented with valid_i low changes neither the history, the lock state nor fail_o.
- R11: alarm_o equals fail_o when diag_sel_i is 4'b0011, and is 0 for every other code.
- R12: When user_pat_we_i is high at a clock edge, the stored user pattern takes the value of user_pat_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 20 | Recovered parallel word, bit 0 earliest |
| valid_i | input | 1 | data_i holds a word this cycle |
| mode_i | input | 3 | Pattern select |
| user_pat_i | input | 20 | User pattern write value |
| user_pat_we_i | input | 1 | Load user_pat_i into the stored pattern |
| diag_sel_i | input | 4 | Diagnostic select, 4'b0011 routes fail to alarm |
| clear_i | input | 1 | Clear the sticky fail flag |
| fail_o | output | 1 | Sticky pattern mismatch flag |
| alarm_o | output | 1 | Routed alarm output |

## Verification
The bench injects a bit error while the checker is still acquiring. A design that judged words too early, or that was armed before lock, would raise a false fail. It feeds all-zero words in a PRBS mode, and a period-20 word that is not the stored pattern in user mode. It then switches to the true stream. A checker that locked onto the wrong seed would flag that stream. It also drives a failing word together with clear_i, and sends garbage with valid_i low. A wrong priority, or a checker that ignores the strobe, would lose the error or invent one. Finally, it walks the diagnostic select codes and changes the user pattern. A loose select decode, or a pattern register that does not load, would give the wrong alarm or stop user mode from locking.

// File: rtl/ptn_pkg.sv
package ptn_pkg;
  localparam logic [2:0] MODE_OFF  = 3'b000;
  localparam logic [2:0] MODE_ALT  = 3'b001;
  localparam logic [2:0] MODE_P7   = 3'b010;
  localparam logic [2:0] MODE_P23  = 3'b011;
  localparam logic [2:0] MODE_P31  = 3'b100;
  localparam logic [2:0] MODE_USER = 3'b101;

  localparam int P7_LEN  = 7;
  localparam int P7_TAP  = 6;
  localparam int P23_LEN = 23;
  localparam int P23_TAP = 18;
  localparam int P31_LEN = 31;
  localparam int P31_TAP = 28;

  function automatic logic mode_enabled(input logic [2:0] m);
    return (m >= MODE_ALT) && (m <= MODE_USER);
  endfunction

  // history depth needed before a word can be judged
  function automatic int need_bits(input logic [2:0] m, input int usr_w);
    case (m)
      MODE_ALT:  return 1;
      MODE_P7:   return P7_LEN;
      MODE_P23:  return P23_LEN;
      MODE_P31:  return P31_LEN;
      MODE_USER: return usr_w;
      default:   return 0;
    endcase
  endfunction
endpackage

// File: rtl/ptn_user_reg.sv
module ptn_user_reg #(
  parameter int              UPW     = 20,
  parameter logic [UPW-1:0]  RST_VAL = 20'h66666
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [UPW-1:0] pat_i,
  output logic [UPW-1:0] pat_o
);
  logic [UPW-1:0] pat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pat_q <= RST_VAL;
    else if (we_i) pat_q <= pat_i;
  end

  assign pat_o = pat_q;

  // R12
  user_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (pat_q == $past(pat_i)));
endmodule

// File: rtl/ptn_predict.sv
module ptn_predict
  import ptn_pkg::*;
#(
  parameter int W   = 20,
  parameter int UPW = 20,
  parameter int HL  = 31
) (
  input  logic [2:0]    mode_i,
  input  logic          locked_i,
  input  logic [HL-1:0] hist_i,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  mism_o,
  output logic [HL-1:0] hist_nxt_o
);
  // bit-serial unroll: h[0] is the newest bit
  always_comb begin
    logic [HL-1:0] h;
    logic          p;
    h      = hist_i;
    mism_o = '0;
    for (int i = 0; i < W; i++) begin
      case (mode_i)
        MODE_ALT:  p = ~h[0];
        MODE_P7:   p = h[P7_LEN-1]  ^ h[P7_TAP-1];
        MODE_P23:  p = h[P23_LEN-1] ^ h[P23_TAP-1];
        MODE_P31:  p = h[P31_LEN-1] ^ h[P31_TAP-1];
        MODE_USER: p = h[UPW-1];
        default:   p = data_i[i];
      endcase
      mism_o[i] = p ^ data_i[i];
      // acquiring: seed from line; locked: free-run on prediction
      h = {h[HL-2:0], (locked_i ? p : data_i[i])};
    end
    hist_nxt_o = h;
  end
endmodule

// File: rtl/ptn_seed_qual.sv
module ptn_seed_qual
  import ptn_pkg::*;
#(
  parameter int UPW = 20,
  parameter int HL  = 31
) (
  input  logic [2:0]     mode_i,
  input  logic [HL-1:0]  hist_i,
  input  logic [UPW-1:0] pat_i,
  output logic           seed_ok_o
);
  logic [UPW-1:0] rot_hit;

  // hist[j] pairs with pat[(k-j) mod UPW] when the newest bit is pat[k]
  for (genvar k = 0; k < UPW; k++) begin : g_rot
    logic [UPW-1:0] cand;
    for (genvar j = 0; j < UPW; j++) begin : g_bit
      assign cand[j] = pat_i[(k - j + UPW) % UPW];
    end
    assign rot_hit[k] = (hist_i[UPW-1:0] == cand);
  end

  always_comb begin
    case (mode_i)
      MODE_P7:   seed_ok_o = |hist_i[P7_LEN-1:0];
      MODE_P23:  seed_ok_o = |hist_i[P23_LEN-1:0];
      MODE_P31:  seed_ok_o = |hist_i[P31_LEN-1:0];
      MODE_USER: seed_ok_o = |rot_hit;
      default:   seed_ok_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ptn_sync_ctrl.sv
module ptn_sync_ctrl
  import ptn_pkg::*;
#(
  parameter int W   = 20,
  parameter int UPW = 20,
  parameter int HL  = 31
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    mode_i,
  input  logic          clear_i,
  input  logic [W-1:0]  mism_i,
  input  logic [HL-1:0] hist_nxt_i,
  input  logic          seed_ok_i,
  output logic [2:0]    mode_q_o,
  output logic [HL-1:0] hist_o,
  output logic          locked_o,
  output logic          fail_o
);
  localparam int FW = $clog2(HL + W + 1);

  logic [2:0]    mode_q;
  logic [HL-1:0] hist_q;
  logic [FW-1:0] fill_q, fill_sum, fill_nxt, need;
  logic          locked_q, fail_q;
  logic          en, mode_chg, chk, armed, lock_go, fail_set;

  assign en       = mode_enabled(mode_q);
  assign need     = FW'(need_bits(mode_q, UPW));
  assign fill_sum = fill_q + FW'(W);
  assign fill_nxt = (fill_sum > FW'(HL)) ? FW'(HL) : fill_sum;
  assign mode_chg = (mode_i != mode_q);
  assign chk      = valid_i && en && !mode_chg;
  assign armed    = (fill_q >= need);
  assign lock_go  = chk && !locked_q && armed && !(|mism_i) && seed_ok_i;
  assign fail_set = chk && locked_q && (|mism_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_OFF;
      hist_q   <= '0;
      fill_q   <= '0;
      locked_q <= 1'b0;
      fail_q   <= 1'b0;
    end else if (mode_chg) begin
      mode_q   <= mode_i;
      fill_q   <= '0;
      locked_q <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      if (chk) begin
        hist_q <= hist_nxt_i;
        fill_q <= fill_nxt;
      end
      if (lock_go)       locked_q <= 1'b1;
      if (fail_set)      fail_q   <= 1'b1;
      else if (clear_i)  fail_q   <= 1'b0;
    end
  end

  assign mode_q_o = mode_q;
  assign hist_o   = hist_q;
  assign locked_o = locked_q;
  assign fail_o   = fail_q;

  // R2
  off_no_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !fail_q);

  // R6
  fail_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> $past(locked_q));

  // R8
  locked_err_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && en && locked_q && (|mism_i) && !mode_chg) |=> fail_q);

  // R9
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !clear_i && !mode_chg) |=> fail_q);

  // R10
  invalid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i && !mode_chg) |=> ($stable(fail_q) && $stable(locked_q) && $stable(hist_q)));
endmodule

// File: rtl/ptn_checker.sv
module ptn_checker
  import ptn_pkg::*;
#(
  parameter int              DATA_W    = 20,
  parameter int              USR_W     = 20,
  parameter logic [USR_W-1:0] USR_RST  = 20'h66666,
  parameter int              DIAG_W    = 4,
  parameter logic [DIAG_W-1:0] ALARM_SEL = 4'b0011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic [2:0]        mode_i,
  input  logic [USR_W-1:0]  user_pat_i,
  input  logic              user_pat_we_i,
  input  logic [DIAG_W-1:0] diag_sel_i,
  input  logic              clear_i,
  output logic              fail_o,
  output logic              alarm_o
);
  localparam int HL = (USR_W > P31_LEN) ? USR_W : P31_LEN;

  logic [USR_W-1:0]  pat;
  logic [2:0]        mode_q;
  logic [HL-1:0]     hist, hist_nxt;
  logic [DATA_W-1:0] mism;
  logic              locked, seed_ok, fail;

  ptn_user_reg #(.UPW(USR_W), .RST_VAL(USR_RST)) u_ureg (
    .clk_i, .rst_ni, .we_i(user_pat_we_i), .pat_i(user_pat_i), .pat_o(pat)
  );

  ptn_predict #(.W(DATA_W), .UPW(USR_W), .HL(HL)) u_pred (
    .mode_i(mode_q), .locked_i(locked), .hist_i(hist), .data_i(data_i),
    .mism_o(mism), .hist_nxt_o(hist_nxt)
  );

  ptn_seed_qual #(.UPW(USR_W), .HL(HL)) u_qual (
    .mode_i(mode_q), .hist_i(hist_nxt), .pat_i(pat), .seed_ok_o(seed_ok)
  );

  ptn_sync_ctrl #(.W(DATA_W), .UPW(USR_W), .HL(HL)) u_ctrl (
    .clk_i, .rst_ni, .valid_i, .mode_i, .clear_i,
    .mism_i(mism), .hist_nxt_i(hist_nxt), .seed_ok_i(seed_ok),
    .mode_q_o(mode_q), .hist_o(hist), .locked_o(locked), .fail_o(fail)
  );

  assign fail_o  = fail;
  assign alarm_o = fail & (diag_sel_i == ALARM_SEL);

  // R11
  alarm_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o |-> fail_o) and ((fail_o && diag_sel_i == ALARM_SEL) |-> alarm_o));
endmodule

// File: tb/sim_ptn_checker.sv
`timescale 1ns/1ps
module sim_ptn_checker;
  localparam int W = 20;

  typedef struct packed {
    logic [2:0] mode;
    logic [7:0] nw;
    logic [7:0] ew;   // 8'hFF = no error
    logic [4:0] eb;
    logic [3:0] diag;
    logic       ef;
    logic       ea;
  } vec_t;

  localparam vec_t VEC [0:12] = '{
    '{3'b001, 8'd6, 8'hFF, 5'd0,  4'h3, 1'b0, 1'b0},
    '{3'b001, 8'd6, 8'd4,  5'd3,  4'h3, 1'b1, 1'b1},
    '{3'b010, 8'd6, 8'd4,  5'd7,  4'h0, 1'b1, 1'b0},
    '{3'b011, 8'd8, 8'hFF, 5'd0,  4'h3, 1'b0, 1'b0},
    '{3'b011, 8'd8, 8'd6,  5'd10, 4'h3, 1'b1, 1'b1},
    '{3'b100, 8'd8, 8'hFF, 5'd0,  4'h3, 1'b0, 1'b0},
    '{3'b100, 8'd8, 8'd6,  5'd19, 4'h3, 1'b1, 1'b1},
    '{3'b100, 8'd6, 8'd0,  5'd5,  4'h3, 1'b0, 1'b0},
    '{3'b101, 8'd6, 8'hFF, 5'd0,  4'h3, 1'b0, 1'b0},
    '{3'b101, 8'd6, 8'd5,  5'd0,  4'h3, 1'b1, 1'b1},
    '{3'b110, 8'd6, 8'd2,  5'd4,  4'h3, 1'b0, 1'b0},
    '{3'b000, 8'd6, 8'd2,  5'd4,  4'h3, 1'b0, 1'b0},
    '{3'b010, 8'd6, 8'd1,  5'd2,  4'h3, 1'b0, 1'b0}
  };

  logic         clk = 0;
  logic         rst_n = 0;
  logic [W-1:0] data = '0;
  logic         valid = 0;
  logic [2:0]   mode = 3'b000;
  logic [19:0]  upat = '0;
  logic         upat_we = 0;
  logic [3:0]   diag = 4'h3;
  logic         clear = 0;
  logic         fail, alarm;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [63:0] bsh;
  int          ph;
  logic        alt_b;
  logic [19:0] bpat = 20'h66666;

  always #4 clk = ~clk;

  ptn_checker u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid), .mode_i(mode),
    .user_pat_i(upat), .user_pat_we_i(upat_we), .diag_sel_i(diag), .clear_i(clear),
    .fail_o(fail), .alarm_o(alarm)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic gen_reset();
    bsh = 64'h1234_5678_9ABC_DEF1; ph = 7; alt_b = 1'b0;
  endtask

  task automatic next_bit(input logic [2:0] m, output logic b);
    case (m)
      3'b001: begin alt_b = ~alt_b; b = alt_b; end
      3'b011: b = bsh[22] ^ bsh[17];
      3'b100: b = bsh[30] ^ bsh[27];
      3'b101: begin b = bpat[ph]; ph = (ph + 1) % 20; end
      default: b = bsh[6] ^ bsh[5];
    endcase
    bsh = {bsh[62:0], b};
  endtask

  task automatic make_word(input logic [2:0] m, output logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      logic b;
      next_bit(m, b);
      w[i] = b;
    end
  endtask

  task automatic drive(input logic [W-1:0] w, input logic v);
    @(negedge clk); data = w; valid = v;
  endtask

  task automatic idle();
    @(negedge clk); valid = 0; clear = 0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); valid = 0; mode = 3'b000;
    @(negedge clk); mode = m;
    gen_reset();
  endtask

  task automatic stream(input logic [2:0] m, input int n, input int ew, input int eb);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] wd;
      make_word(m, wd);
      if (k == ew) wd[eb] = ~wd[eb];
      drive(wd, 1'b1);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.mode == 3'b000 || v.mode >= 3'b110) return "R2";
    if (v.ef) return "R8";
    if (v.ew != 8'hFF) return "R6";
    case (v.mode)
      3'b001:  return "R3";
      3'b101:  return "R5";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 fail after reset", fail, 1'b0);
    check("R1 alarm after reset", alarm, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 fail idle", fail, 1'b0);

    // table walk
    foreach (VEC[n]) begin
      vec_t v;
      v = VEC[n];
      diag = v.diag;
      set_mode(v.mode);
      stream(v.mode, int'(v.nw), (v.ew == 8'hFF) ? -1 : int'(v.ew), int'(v.eb));
      idle();
      check(tag_of(v), fail, v.ef);
      check("R11 vector alarm", alarm, v.ea);
    end

    // R11: select decode with fail held
    diag = 4'h3;
    set_mode(3'b010);
    stream(3'b010, 4, 3, 0);
    idle();
    check("R8 directed set", fail, 1'b1);
    foreach (VEC[n]) begin
      logic [3:0] d;
      d = VEC[n].eb[3:0] ^ 4'h5;
      diag = d; #1;
      check("R11 select decode", alarm, d == 4'h3);
    end
    diag = 4'h3; #1;
    check("R11 select 0011", alarm, 1'b1);

    // R9: clear removes flag, stays set while not cleared
    repeat (3) @(negedge clk);
    check("R9 sticky", fail, 1'b1);
    clear = 1; idle();
    check("R9 clear", fail, 1'b0);

    // R9: error and clear together -> set
    stream(3'b010, 1, -1, 0);
    begin
      logic [W-1:0] wd;
      make_word(3'b010, wd);
      wd[9] = ~wd[9];
      @(negedge clk); data = wd; valid = 1; clear = 1;
    end
    idle();
    check("R9 set beats clear", fail, 1'b1);

    // R9: mode change clears
    @(negedge clk); mode = 3'b011;
    @(negedge clk);
    check("R9 mode change clears", fail, 1'b0);

    // R10: invalid garbage ignored while locked
    set_mode(3'b010);
    stream(3'b010, 4, -1, 0);
    for (int k = 0; k < 3; k++) drive(20'hA5A5A ^ W'(k), 1'b0);
    stream(3'b010, 3, -1, 0);
    idle();
    check("R10 valid low ignored", fail, 1'b0);

    // R7: zero seed must not lock
    set_mode(3'b100);
    for (int k = 0; k < 4; k++) drive('0, 1'b1);
    stream(3'b100, 6, -1, 0);
    idle();
    check("R7 zero seed", fail, 1'b0);

    // R5: period-20 word that is not a rotation of the stored pattern
    set_mode(3'b101);
    for (int k = 0; k < 4; k++) drive(20'h12345, 1'b1);
    stream(3'b101, 5, -1, 0);
    idle();
    check("R5 wrong pattern no lock", fail, 1'b0);

    // R12: new pattern
    @(negedge clk); upat = 20'hABCDE; upat_we = 1;
    @(negedge clk); upat_we = 0; bpat = 20'hABCDE;
    set_mode(3'b101);
    stream(3'b101, 6, -1, 0);
    idle();
    check("R12 new pattern clean", fail, 1'b0);
    stream(3'b101, 2, 1, 13);
    idle();
    check("R12 new pattern locked", fail, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule